// File: doc/BRIEF.md
# Polled Two-Client Burst Arbiter for a Shared SDRAM Controller

This block lets two clients share one SDRAM controller. One client reads frames out of memory toward a video encoder, and the other writes frames coming in from a video decoder. While idle, the arbiter moves between a wait state and a poll state on every clock. In each poll cycle it raises one poll strobe that both clients see. A client that needs a transfer answers by raising its ready line. The arbiter then grants one client and latches that client's address. It asks the controller for a read or a write and holds the request until the controller accepts it.

Each grant moves exactly one burst of eight 32-bit words. The grant strobe drives the client's FIFO enable. For the write client it pops one word on each transfer cycle. For the read client it pushes a word only when the controller marks the read data valid. When the last word has moved, the arbiter waits for the controller's done pulse, drops the serving flag and goes back to polling. If both clients answer the same poll, the one that was not served last wins.

The latched address is split into an SDRAM row, a column and a bank. The low field is the burst index. Above it is a one-bit field flag, and above that is the pixel row.

Top module: `sdarb_top`

## Requirements
- R1: While reset is held and in the first cycle after reset is released, poll, both serving flags, both controller requests and both data-request strobes are low. Poll rises in the second cycle after release.
- R2: While neither client is ready and no burst is in progress, poll is high on every other cycle.
- R3: A ready line that is high when the clock samples a poll cycle gives a grant in the next cycle. That client's serving flag rises, together with the matching controller request: mem_rd_req for the read client, mem_wr_req for the write client.
- R4: The controller request stays high, and neither data-request strobe is asserted, until mem_ready is sampled high. The transfer begins in the cycle after that.
- R5: For a write burst, wr_data_req is high for exactly 8 consecutive cycles, starting the cycle after mem_ready is accepted. During those cycles mem_wdata equals wr_data.
- R6: For a read burst, rd_data_req is high only in cycles where mem_rvalid is high, up to 8 valid words. In those cycles rd_data equals mem_rdata, and in all other cycles rd_data is zero. Valid words after the eighth are not forwarded.
- R7: serving_rd and serving_wr are never high together. A serving flag stays high until mem_done is sampled after the burst has finished. It is low in the next cycle, and poll is high in the cycle after that.
- R8: Address mapping, with a = latched 24-bit client address:
  - mem_row = {4'b0000, a[14:7], a[6]}, where a[14:7] is the pixel row and a[6] is the field flag.
  - mem_col = {a[5:0], 3'b000}, where a[5:0] is the burst index.
  - mem_bank = 2'b00.
  - Bits a[23:15] do not affect any output.
- R9: When both clients are ready in the same poll cycle, the client not granted last wins. After reset the read client wins the first tie.
- R10: Ready lines are ignored outside poll cycles. A client raising ready during another client's burst does not change either serving flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_ready | input | 1 | Controller accepts the pending request |
| mem_done | input | 1 | Controller signals the burst is complete |
| mem_rvalid | input | 1 | Controller read data is valid this cycle |
| mem_rdata | input | 32 | Read data from the controller |
| mem_wdata | output | 32 | Write data to the controller |
| mem_rd_req | output | 1 | Read request to the controller |
| mem_wr_req | output | 1 | Write request to the controller |
| mem_row | output | 13 | SDRAM row address |
| mem_col | output | 9 | SDRAM column address, burst aligned |
| mem_bank | output | 2 | SDRAM bank address, always zero |
| poll | output | 1 | Poll strobe broadcast to both clients |
| serving_rd | output | 1 | Read client currently granted |
| serving_wr | output | 1 | Write client currently granted |
| rd_data | output | 32 | Read data to the read client FIFO |
| rd_addr | input | 24 | Burst address from the read client |
| rd_ready | input | 1 | Read client needs a burst |
| rd_data_req | output | 1 | Write enable of the read client FIFO |
| wr_data | input | 32 | Data from the write client FIFO |
| wr_addr | input | 24 | Burst address from the write client |
| wr_ready | input | 1 | Write client needs a burst |
| wr_data_req | output | 1 | Read enable of the write client FIFO |

## Verification
The checker watches several rules on every cycle:
- The serving flags are never high together.
- Every data-request strobe and controller request belongs to the client being served.
- A read strobe never appears without read-valid.
- A granted poll is always followed by a serving flag.
- A flag drops only after done.
- No grant carries more than eight strobes, and the burst ends on the eighth.

Other properties can only be shown by the bench scenarios, because they depend on values or on history:
- the exact row and column split of the address;
- which client wins a tie, given the previous grant;
- stalls while mem_ready is low;
- gaps in read-valid;
- a waiting client being ignored during another client's burst.

// File: rtl/sdarb_pkg.sv
package sdarb_pkg;
  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_POLL = 3'd1,
    ST_REQ  = 3'd2,
    ST_XFER = 3'd3,
    ST_FIN  = 3'd4
  } arb_state_e;
endpackage

// File: rtl/sdarb_addr_fmt.sv
module sdarb_addr_fmt #(
  parameter int ADDR_W      = 24,
  parameter int BURST_IDX_W = 6,
  parameter int PIX_ROW_W   = 8,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int BANK_W      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank
);
  localparam int USED_W  = BURST_IDX_W + 1 + PIX_ROW_W;
  localparam int COL_LSB = COL_W - BURST_IDX_W;

  // row: pixel row above the field flag, zero padded on top
  function automatic logic [ROW_W-1:0] row_of(input logic [USED_W-1:0] a);
    logic [ROW_W-1:0] r;
    r = '0;
    r[PIX_ROW_W:0] = a[USED_W-1:BURST_IDX_W];
    return r;
  endfunction

  // column: burst index shifted so each access starts on a burst boundary
  function automatic logic [COL_W-1:0] col_of(input logic [USED_W-1:0] a);
    logic [COL_W-1:0] c;
    c = '0;
    c[COL_W-1:COL_LSB] = a[BURST_IDX_W-1:0];
    return c;
  endfunction

  logic [USED_W-1:0] used_bits;
  assign used_bits = addr[USED_W-1:0];

  generate
    if (ADDR_W > USED_W) begin : g_spare
      logic unused_upper_bits;
      assign unused_upper_bits = ^addr[ADDR_W-1:USED_W];
    end
  endgenerate

  assign row  = row_of(used_bits);
  assign col  = col_of(used_bits);
  assign bank = '0;
endmodule

// File: rtl/sdarb_fsm.sv
module sdarb_fsm
  import sdarb_pkg::*;
#(
  parameter int BURST_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_ready,
  input  logic wr_ready,
  input  logic mem_ready,
  input  logic mem_done,
  input  logic mem_rvalid,
  output logic poll,
  output logic grant_fire,
  output logic grant_wr,
  output logic sel_wr,
  output logic busy,
  output logic in_req,
  output logic in_xfer,
  output logic beat,
  output logic burst_last
);
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_LEN - 1);

  arb_state_e       state_q;
  logic             last_wr_q;
  logic [CNT_W-1:0] cnt_q;

  // alternating priority: on a tie the client not served last wins
  function automatic logic choose_writer(input logic rd, input logic wr,
                                         input logic last_was_wr);
    if (rd && wr) return !last_was_wr;
    return wr;
  endfunction

  assign poll       = (state_q == ST_POLL);
  assign grant_fire = poll && (rd_ready || wr_ready);
  assign grant_wr   = choose_writer(rd_ready, wr_ready, last_wr_q);
  assign in_req     = (state_q == ST_REQ);
  assign in_xfer    = (state_q == ST_XFER);
  assign busy       = in_req || in_xfer || (state_q == ST_FIN);
  assign beat       = in_xfer && (sel_wr || mem_rvalid);
  assign burst_last = beat && (cnt_q == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_WAIT;
      sel_wr    <= 1'b0;
      last_wr_q <= 1'b1;
      cnt_q     <= '0;
    end else begin
      case (state_q)
        ST_WAIT: state_q <= ST_POLL;
        ST_POLL: begin
          if (grant_fire) begin
            state_q   <= ST_REQ;
            sel_wr    <= grant_wr;
            last_wr_q <= grant_wr;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_REQ: begin
          if (mem_ready) begin
            state_q <= ST_XFER;
            cnt_q   <= '0;
          end
        end
        ST_XFER: begin
          if (beat) begin
            cnt_q <= cnt_q + 1'b1;
            if (burst_last) state_q <= ST_FIN;
          end
        end
        ST_FIN: if (mem_done) state_q <= ST_WAIT;
        default: state_q <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/sdarb_top.sv
module sdarb_top #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 24,
  parameter int BURST_LEN   = 8,
  parameter int BURST_IDX_W = 6,
  parameter int PIX_ROW_W   = 8,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int BANK_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_ready,
  input  logic              mem_done,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ROW_W-1:0]  mem_row,
  output logic [COL_W-1:0]  mem_col,
  output logic [BANK_W-1:0] mem_bank,
  output logic              poll,
  output logic              serving_rd,
  output logic              serving_wr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  output logic              rd_data_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_ready,
  output logic              wr_data_req
);
  logic grant_fire, grant_wr, sel_wr, busy, in_req, in_xfer, beat, burst_last;
  logic [ADDR_W-1:0] addr_q;

  sdarb_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rd_ready   (rd_ready),
    .wr_ready   (wr_ready),
    .mem_ready  (mem_ready),
    .mem_done   (mem_done),
    .mem_rvalid (mem_rvalid),
    .poll       (poll),
    .grant_fire (grant_fire),
    .grant_wr   (grant_wr),
    .sel_wr     (sel_wr),
    .busy       (busy),
    .in_req     (in_req),
    .in_xfer    (in_xfer),
    .beat       (beat),
    .burst_last (burst_last)
  );

  // latch the winner's address at grant; held for the whole burst
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (grant_fire) addr_q <= grant_wr ? wr_addr : rd_addr;
  end

  sdarb_addr_fmt #(
    .ADDR_W(ADDR_W), .BURST_IDX_W(BURST_IDX_W), .PIX_ROW_W(PIX_ROW_W),
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)
  ) u_addr (
    .addr (addr_q),
    .row  (mem_row),
    .col  (mem_col),
    .bank (mem_bank)
  );

  assign serving_rd  = busy && !sel_wr;
  assign serving_wr  = busy && sel_wr;
  assign mem_rd_req  = in_req && !sel_wr;
  assign mem_wr_req  = in_req && sel_wr;
  assign wr_data_req = in_xfer && sel_wr;
  assign rd_data_req = in_xfer && !sel_wr && mem_rvalid;
  assign mem_wdata   = wr_data;
  assign rd_data     = rd_data_req ? mem_rdata : '0;
endmodule

// File: rtl/sdarb_checker.sv
module sdarb_checker #(
  parameter int BURST_LEN = 8
) (
  input logic clk,
  input logic rst,
  input logic poll,
  input logic rd_ready,
  input logic wr_ready,
  input logic serving_rd,
  input logic serving_wr,
  input logic mem_rd_req,
  input logic mem_wr_req,
  input logic mem_done,
  input logic mem_rvalid,
  input logic rd_data_req,
  input logic wr_data_req,
  input logic grant_fire,
  input logic burst_last
);
  localparam int SEEN_W = $clog2(BURST_LEN + 1) + 1;
  logic [SEEN_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (grant_fire) seen_q <= '0;
    else if (rd_data_req || wr_data_req) seen_q <= seen_q + 1'b1;
  end

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(serving_rd && serving_wr));

  assert_idle_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (!poll && !serving_rd && !serving_wr) |=> poll);

  assert_poll_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (poll && !rd_ready && !wr_ready) |=> !poll);

  assert_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (poll && (rd_ready || wr_ready)) |=> (serving_rd || serving_wr));

  assert_wr_req_owner_R3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> (serving_wr && !mem_rd_req));

  assert_rd_req_owner_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> serving_rd);

  assert_wr_strobe_owner_R5: assert property (@(posedge clk) disable iff (rst)
    wr_data_req |-> (serving_wr && !mem_wr_req));

  assert_rd_strobe_valid_R6: assert property (@(posedge clk) disable iff (rst)
    rd_data_req |-> (serving_rd && mem_rvalid));

  assert_beat_cap_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_data_req || wr_data_req) |-> (seen_q < SEEN_W'(BURST_LEN)));

  assert_burst_len_R5: assert property (@(posedge clk) disable iff (rst)
    burst_last |-> (seen_q == SEEN_W'(BURST_LEN - 1)));

  assert_hold_wr_R7: assert property (@(posedge clk) disable iff (rst)
    (serving_wr && !mem_done) |=> serving_wr);

  assert_hold_rd_R7: assert property (@(posedge clk) disable iff (rst)
    (serving_rd && !mem_done) |=> serving_rd);
endmodule

bind sdarb_top sdarb_checker #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .poll        (poll),
  .rd_ready    (rd_ready),
  .wr_ready    (wr_ready),
  .serving_rd  (serving_rd),
  .serving_wr  (serving_wr),
  .mem_rd_req  (mem_rd_req),
  .mem_wr_req  (mem_wr_req),
  .mem_done    (mem_done),
  .mem_rvalid  (mem_rvalid),
  .rd_data_req (rd_data_req),
  .wr_data_req (wr_data_req),
  .grant_fire  (grant_fire),
  .burst_last  (burst_last)
);

// File: tb/sdarb_top_tb_top.sv
`timescale 1ns/1ps
module sdarb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_ready = 0, mem_done = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = '0, mem_wdata, rd_data, wr_data = '0;
  logic        mem_rd_req, mem_wr_req, poll, serving_rd, serving_wr;
  logic [12:0] mem_row;
  logic [8:0]  mem_col;
  logic [1:0]  mem_bank;
  logic [23:0] rd_addr = '0, wr_addr = '0;
  logic        rd_ready = 0, wr_ready = 0, rd_data_req, wr_data_req;

  int errors = 0;
  int checks = 0;
  logic last_wr = 1'b1;

  always #2.5 clk = ~clk;

  sdarb_top dut_i (
    .clk(clk), .rst(rst), .mem_ready(mem_ready), .mem_done(mem_done),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_row(mem_row),
    .mem_col(mem_col), .mem_bank(mem_bank), .poll(poll),
    .serving_rd(serving_rd), .serving_wr(serving_wr), .rd_data(rd_data),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data_req(rd_data_req),
    .wr_data(wr_data), .wr_addr(wr_addr), .wr_ready(wr_ready),
    .wr_data_req(wr_data_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected mapping, stated independently: field flag and pixel row sit
  // directly above the six-bit burst index
  function automatic logic [12:0] want_row(input logic [23:0] a);
    return 13'(a[14:6]);
  endfunction
  function automatic logic [8:0] want_col(input logic [23:0] a);
    return 9'(a[5:0]) * 9'd8;
  endfunction

  task automatic align();
    for (int k = 0; k < 4 && poll; k++) step();
  endtask

  task automatic check_addr(input logic [23:0] a);
    chk("R8", "row", 32'(mem_row), 32'(want_row(a)));
    chk("R8", "col", 32'(mem_col), 32'(want_col(a)));
    chk("R8", "bank", 32'(mem_bank), 32'd0);
  endtask

  task automatic finish_burst(input logic is_wr);
    if (is_wr) begin
      for (int i = 0; i < 8; i++) step();
    end else begin
      for (int i = 0; i < 8; i++) begin
        mem_rvalid = 1'b1;
        step();
      end
      mem_rvalid = 1'b0;
    end
    mem_done = 1'b1;
    step();
    mem_done = 1'b0;
  endtask

  task automatic t_reset_idle();
    repeat (3) step();
    chk("R1", "poll in reset", 32'(poll), 0);
    rst = 1'b0;
    #1;
    chk("R1", "poll after release", 32'(poll), 0);
    chk("R1", "serving", 32'({serving_rd, serving_wr}), 0);
    chk("R1", "requests", 32'({mem_rd_req, mem_wr_req, rd_data_req, wr_data_req}), 0);
    step();
    chk("R1", "first poll", 32'(poll), 1);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R2", "idle toggle", 32'(poll), 32'(i % 2));
    end
  endtask

  task automatic t_write(input logic [23:0] a, input logic other);
    align();
    wr_addr = a; wr_ready = 1'b1;
    step();
    chk("R3", "poll before grant", 32'(poll), 1);
    step();
    chk("R3", "serving_wr", 32'(serving_wr), 1);
    chk("R7", "serving_rd low", 32'(serving_rd), 0);
    chk("R3", "mem_wr_req", 32'(mem_wr_req), 1);
    chk("R3", "mem_rd_req low", 32'(mem_rd_req), 0);
    check_addr(a);
    wr_ready = 1'b0; rd_ready = other;
    step(); step();
    chk("R4", "request held", 32'(mem_wr_req), 1);
    chk("R4", "no strobe yet", 32'(wr_data_req), 0);
    mem_ready = 1'b1;
    step();
    mem_ready = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wr_data = 32'hA500_0000 + 32'(i) + 32'(a[7:0]);
      #1;
      chk("R5", "wr strobe", 32'(wr_data_req), 1);
      chk("R5", "wdata", mem_wdata, 32'hA500_0000 + 32'(i) + 32'(a[7:0]));
      chk("R10", "other not served", 32'(serving_rd), 0);
      step();
    end
    chk("R5", "strobe after 8", 32'(wr_data_req), 0);
    chk("R7", "held until done", 32'(serving_wr), 1);
    step();
    chk("R7", "still held", 32'(serving_wr), 1);
    mem_done = 1'b1;
    step();
    mem_done = 1'b0; rd_ready = 1'b0;
    chk("R7", "flag cleared", 32'(serving_wr), 0);
    chk("R7", "wait state", 32'(poll), 0);
    step();
    chk("R7", "poll resumes", 32'(poll), 1);
    last_wr = 1'b1;
  endtask

  task automatic t_read(input logic [23:0] a);
    int words;
    align();
    rd_addr = a; rd_ready = 1'b1;
    step(); step();
    chk("R3", "serving_rd", 32'(serving_rd), 1);
    chk("R3", "mem_rd_req", 32'(mem_rd_req), 1);
    check_addr(a);
    rd_ready = 1'b0; mem_ready = 1'b1;
    step();
    mem_ready = 1'b0;
    words = 0;
    for (int i = 0; words < 8 && i < 40; i++) begin
      logic v;
      v = (i % 3) != 1;
      mem_rvalid = v;
      mem_rdata = 32'hC0DE_0000 + 32'(i);
      #1;
      chk("R6", "rd strobe", 32'(rd_data_req), 32'(v));
      chk("R6", "rd data", rd_data, v ? 32'hC0DE_0000 + 32'(i) : 32'd0);
      if (v) words++;
      step();
    end
    mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF;
    #1;
    chk("R6", "extra valid ignored", 32'(rd_data_req), 0);
    chk("R6", "extra data blocked", rd_data, 0);
    mem_rvalid = 1'b0;
    mem_done = 1'b1;
    step();
    mem_done = 1'b0;
    chk("R7", "read flag cleared", 32'(serving_rd), 0);
    last_wr = 1'b0;
  endtask

  task automatic t_tie();
    logic exp_wr;
    align();
    exp_wr = !last_wr;
    rd_addr = 24'h00_0041; wr_addr = 24'h00_0082;
    rd_ready = 1'b1; wr_ready = 1'b1;
    step(); step();
    chk("R9", "tie winner wr", 32'(serving_wr), 32'(exp_wr));
    chk("R9", "tie winner rd", 32'(serving_rd), 32'(!exp_wr));
    check_addr(exp_wr ? 24'h00_0082 : 24'h00_0041);
    rd_ready = 1'b0; wr_ready = 1'b0; mem_ready = 1'b1;
    step();
    mem_ready = 1'b0;
    finish_burst(exp_wr);
    last_wr = exp_wr;
  endtask

  initial begin
    t_reset_idle();
    t_tie();
    t_write({9'h000, 8'd200, 1'b1, 6'd37}, 1'b1);
    t_read({9'h000, 8'd17, 1'b0, 6'd63});
    t_tie();
    t_tie();
    t_write({9'h1A5, 8'd252, 1'b0, 6'd1}, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule